// File: doc/BRIEF.md
# Two-Wire Configuration Bank with Deferred Commit for a Stereo Audio Delay

This block is the two-wire serial configuration slave for a stereo audio delay unit. A bus master addresses it with a 7-bit address: a fixed `1101` prefix followed by three bits taken from strap pins. The master sends a register pointer and then one or more data bytes. Each data byte after the pointer goes to the next register in turn. The block acknowledges every byte it accepts by pulling the data line low during the ninth clock.

Data bytes go into staging registers. The stream type, the two sample delays, the frame delay and the packet length stay at their old active values until a byte with bit 0 set is written to the commit register. That write moves all of the staged values to the active outputs in the same clock cycle and raises a single-cycle update strobe. The two mute bits in the control register are the exception: they drive the outputs as soon as the control byte is written.

The protocol engine is a six-state machine:

- `ST_IDLE`: the bus is free.
- `ST_ADDR`: the address byte is shifted in.
- `ST_ADDR_ACK`: the address is acknowledged.
- `ST_DATA`: a pointer byte or a data byte is shifted in.
- `ST_DATA_ACK`: the byte is acknowledged.
- `ST_SKIP`: the slave ignores the bus until the next START or STOP.

Transitions:

- A START moves any state to `ST_ADDR`. A STOP moves any state to `ST_IDLE`.
- `ST_ADDR` goes to `ST_ADDR_ACK` on the SCL fall after bit 8 if the address matches and the direction bit is write. Otherwise it goes to `ST_SKIP`.
- `ST_ADDR_ACK` goes to `ST_DATA` on the next SCL fall.
- `ST_DATA` goes to `ST_DATA_ACK` on the SCL fall after bit 8. The one exception is a pointer byte above 0x08, which sends it to `ST_SKIP`.
- `ST_DATA_ACK` goes back to `ST_DATA` on the next SCL fall.

Top module: `lipsync_cfg_i2c`

## Requirements
- R1: The slave acknowledges an address byte only if it equals {4'b1101, addr_sel, 1'b0}; for example, 0xD2 when addr_sel is 3'b001. Any other address byte, including a read request, is not acknowledged, and the bus is then ignored until the next START.
- R2: The first byte after the address is the register pointer. The slave acknowledges pointer values 0x00 to 0x08 and does not acknowledge a pointer above 0x08.
- R3: Each later data byte is stored at the pointer, and then the pointer advances by one. Every data byte is acknowledged, including bytes beyond register 0x08, which are discarded.
- R4: The acknowledge drive (sda_oe high) starts only on an SCL falling edge and ends on the next SCL falling edge or at a START or STOP.
- R5: The active outputs act_rj, act_dly_r, act_dly_l, act_frame and act_pkt do not change without a commit.
- R6: Writing a byte with bit 0 set to register 0x08 copies all staged values to the active outputs together; bits 7:1 of that byte are ignored. The mapping is:
  - act_rj from control bit 0 (1 means right-justified, 0 means I2S)
  - act_dly_r from {reg 0x02, reg 0x03}
  - act_dly_l from {reg 0x04, reg 0x05}
  - act_frame from reg 0x06
  - act_pkt from reg 0x07
- R7: Writing a byte with bit 0 clear to register 0x08 changes no active output and raises no update strobe.
- R8: cfg_update is high for exactly one cycle per commit, in the same cycle that the active outputs take their new values.
- R9: Control bit 7 drives mute_l and control bit 6 drives mute_r. Both follow a control write directly, without a commit.
- R10: After reset, all staging and active registers are 0x00 except control, which is 0xC0. The slave therefore starts with both channels muted and in I2S mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line (sampled) |
| sda_i | input | 1 | Serial data line (sampled) |
| sda_oe | output | 1 | Pulls the data line low when high (acknowledge) |
| addr_sel | input | 3 | Strapped low address bits |
| mute_l | output | 1 | Left channel mute, immediate |
| mute_r | output | 1 | Right channel mute, immediate |
| act_rj | output | 1 | Active stream type, 1 means right-justified |
| act_dly_r | output | 16 | Active right delay in samples |
| act_dly_l | output | 16 | Active left delay in samples |
| act_frame | output | 8 | Active frame delay |
| act_pkt | output | 8 | Active right-justified packet length |
| cfg_update | output | 1 | One-cycle strobe when a commit is applied |

## Verification
The bench drives several kinds of transfer:

- A long sequential burst that ends in a commit. This shows that auto-increment maps each byte to the right register.
- Staged writes with no commit, then a commit byte with bit 0 clear, then one with bit 0 set. These separate staging from transfer.
- Single control writes. These show that mute acts at once while the stream type waits for a commit.
- Foreign addresses, a read request, a strap change and an out-of-range pointer. These test address matching and NACK behaviour.

// File: rtl/lipsync_cfg_pkg.sv
package lipsync_cfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_SKIP
    } bus_state_t;

    localparam logic [3:0] DEV_PREFIX = 4'b1101;
    localparam int         LAST_REG   = 8;

endpackage

// File: rtl/lipsync_line_sync.sv
module lipsync_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_sh;
    logic [SYNC_STAGES-1:0] sda_sh;
    logic scl_s;
    logic scl_p;
    logic sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
            scl_p  <= scl_sh[SYNC_STAGES-1];
            sda_p  <= sda_sh[SYNC_STAGES-1];
        end
    end

    assign scl_s     = scl_sh[SYNC_STAGES-1];
    assign sda_s     = sda_sh[SYNC_STAGES-1];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/lipsync_bus_fsm.sv
module lipsync_bus_fsm
    import lipsync_cfg_pkg::*;
#(
    parameter int PIN_BITS = 3,
    parameter int DW       = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sda_s,
    input  logic                scl_rise,
    input  logic                scl_fall,
    input  logic                start_det,
    input  logic                stop_det,
    input  logic [PIN_BITS-1:0] addr_pins,
    output logic                sda_oe,
    output logic                byte_stb,
    output logic                byte_is_ptr,
    output logic [DW-1:0]       byte_val
);
    localparam int CW = $clog2(DW + 1);
    localparam logic [CW-1:0] FULL = CW'(DW);

    bus_state_t    state, nxt;
    logic [DW-1:0] shreg;
    logic [CW-1:0] bitcnt;
    logic          first;
    logic          byte_done;
    logic          addr_ok;

    assign byte_done = scl_fall && (bitcnt == FULL);
    assign addr_ok   = (shreg == {DEV_PREFIX, addr_pins, 1'b0});

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     nxt = ST_IDLE;
            ST_ADDR:     if (byte_done) nxt = addr_ok ? ST_ADDR_ACK : ST_SKIP;
            ST_ADDR_ACK: if (scl_fall) nxt = ST_DATA;
            ST_DATA:     if (byte_done)
                             nxt = (first && (shreg > DW'(LAST_REG))) ? ST_SKIP : ST_DATA_ACK;
            ST_DATA_ACK: if (scl_fall) nxt = ST_DATA;
            ST_SKIP:     nxt = ST_SKIP;
            default:     nxt = ST_IDLE;
        endcase
        if (stop_det)  nxt = ST_IDLE;
        if (start_det) nxt = ST_ADDR;
    end

    // datapath: shifter, bit counter, pointer flag, byte hand-off
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg       <= '0;
            bitcnt      <= '0;
            first       <= 1'b1;
            byte_stb    <= 1'b0;
            byte_is_ptr <= 1'b0;
            byte_val    <= '0;
        end else begin
            byte_stb <= 1'b0;
            if (start_det || stop_det) begin
                bitcnt <= '0;
                first  <= 1'b1;
            end else begin
                if (scl_rise && (state == ST_ADDR || state == ST_DATA) && bitcnt < FULL) begin
                    shreg  <= {shreg[DW-2:0], sda_s};
                    bitcnt <= bitcnt + 1'b1;
                end
                if (scl_fall && (state == ST_ADDR_ACK || state == ST_DATA_ACK))
                    bitcnt <= '0;
                if (state == ST_DATA && nxt == ST_DATA_ACK) begin
                    byte_stb    <= 1'b1;
                    byte_is_ptr <= first;
                    byte_val    <= shreg;
                    first       <= 1'b0;
                end
            end
        end
    end

    // outputs
    always_comb begin
        sda_oe = (state == ST_ADDR_ACK) || (state == ST_DATA_ACK);
    end

    AST_ACK_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall)); // R4
    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> $past(scl_fall || start_det || stop_det)); // R4
    AST_SKIP_NO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |=> !byte_stb); // R1

endmodule

// File: rtl/lipsync_cfg_bank.sv
module lipsync_cfg_bank
    import lipsync_cfg_pkg::*;
#(
    parameter int          DW       = 8,
    parameter logic [7:0]  CTRL_RST = 8'hC0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_stb,
    input  logic          byte_is_ptr,
    input  logic [DW-1:0] byte_val,
    output logic          mute_l,
    output logic          mute_r,
    output logic          act_rj,
    output logic [2*DW-1:0] act_dly_r,
    output logic [2*DW-1:0] act_dly_l,
    output logic [DW-1:0] act_frame,
    output logic [DW-1:0] act_pkt,
    output logic          cfg_update
);
    localparam int NSTG     = LAST_REG - 1;
    localparam int IX_CTRL  = 0;
    localparam int IX_RH    = 1;
    localparam int IX_RL    = 2;
    localparam int IX_LH    = 3;
    localparam int IX_LL    = 4;
    localparam int IX_FRAME = 5;
    localparam int IX_PKT   = 6;

    logic [DW-1:0] stg [NSTG];
    logic [DW-1:0] ptr;
    logic          data_wr;
    logic          commit_q;

    assign data_wr = byte_stb && !byte_is_ptr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (byte_stb) begin
            if (byte_is_ptr)        ptr <= byte_val;
            else if (ptr != '1)     ptr <= ptr + 1'b1;
        end
    end

    for (genvar g = 0; g < NSTG; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                stg[g] <= (g == IX_CTRL) ? DW'(CTRL_RST) : '0;
            else if (data_wr && ptr == DW'(g + 1))
                stg[g] <= byte_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) commit_q <= 1'b0;
        else        commit_q <= data_wr && (ptr == DW'(LAST_REG)) && byte_val[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_rj     <= 1'b0;
            act_dly_r  <= '0;
            act_dly_l  <= '0;
            act_frame  <= '0;
            act_pkt    <= '0;
            cfg_update <= 1'b0;
        end else begin
            cfg_update <= commit_q;
            if (commit_q) begin
                act_rj    <= stg[IX_CTRL][0];
                act_dly_r <= {stg[IX_RH], stg[IX_RL]};
                act_dly_l <= {stg[IX_LH], stg[IX_LL]};
                act_frame <= stg[IX_FRAME];
                act_pkt   <= stg[IX_PKT];
            end
        end
    end

    assign mute_l = stg[IX_CTRL][7];
    assign mute_r = stg[IX_CTRL][6];

    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_q |=> ($stable(act_dly_r) && $stable(act_dly_l) && $stable(act_frame)
                       && $stable(act_pkt) && $stable(act_rj))); // R5
    AST_COMMIT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        commit_q |=> (cfg_update && act_frame == $past(stg[IX_FRAME])
                      && act_pkt == $past(stg[IX_PKT]))); // R6
    AST_ZERO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && ptr == DW'(LAST_REG) && !byte_val[0]) |=> ##1 !cfg_update); // R7
    AST_UPD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_update |=> !cfg_update); // R8
    AST_MUTE_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && ptr == DW'(1)) |=> (mute_l == $past(byte_val[7])
                                        && mute_r == $past(byte_val[6]))); // R9

endmodule

// File: rtl/lipsync_cfg_i2c.sv
module lipsync_cfg_i2c #(
    parameter int         PIN_BITS    = 3,
    parameter int         DW          = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] CTRL_RST    = 8'hC0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    output logic                sda_oe,
    input  logic [PIN_BITS-1:0] addr_sel,
    output logic                mute_l,
    output logic                mute_r,
    output logic                act_rj,
    output logic [2*DW-1:0]     act_dly_r,
    output logic [2*DW-1:0]     act_dly_l,
    output logic [DW-1:0]       act_frame,
    output logic [DW-1:0]       act_pkt,
    output logic                cfg_update
);
    logic          sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic          byte_stb, byte_is_ptr;
    logic [DW-1:0] byte_val;

    lipsync_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    lipsync_bus_fsm #(.PIN_BITS(PIN_BITS), .DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .addr_pins(addr_sel), .sda_oe(sda_oe), .byte_stb(byte_stb),
        .byte_is_ptr(byte_is_ptr), .byte_val(byte_val)
    );

    lipsync_cfg_bank #(.DW(DW), .CTRL_RST(CTRL_RST)) u_bank (
        .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb), .byte_is_ptr(byte_is_ptr),
        .byte_val(byte_val), .mute_l(mute_l), .mute_r(mute_r), .act_rj(act_rj),
        .act_dly_r(act_dly_r), .act_dly_l(act_dly_l), .act_frame(act_frame),
        .act_pkt(act_pkt), .cfg_update(cfg_update)
    );

endmodule

// File: tb/sim_lipsync_cfg_i2c.sv
module sim_lipsync_cfg_i2c;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic [2:0] addr_sel = 3'b001;
    logic sda_oe, mute_l, mute_r, act_rj, cfg_update;
    logic [15:0] act_dly_r, act_dly_l;
    logic [7:0] act_frame, act_pkt;
    logic sda_bus;
    int checks = 0;
    int fails = 0;
    int upd_cnt = 0;

    assign sda_bus = m_sda & ~sda_oe;
    always #10 clk = ~clk;

    lipsync_cfg_i2c u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
        .addr_sel(addr_sel), .mute_l(mute_l), .mute_r(mute_r), .act_rj(act_rj),
        .act_dly_r(act_dly_r), .act_dly_l(act_dly_l), .act_frame(act_frame),
        .act_pkt(act_pkt), .cfg_update(cfg_update)
    );

    always @(negedge clk) if (rst_n && cfg_update) upd_cnt++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
        m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q);
        m_sda = 1'b1; wq(2 * Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wq(Q); m_scl = 1'b1; wq(2 * Q); m_scl = 1'b0; wq(Q);
        end
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
        ack = (sda_bus == 1'b0);
        wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    // returns index of first unacknowledged byte (0 = address), -1 when all acked
    task automatic xfer(input logic [7:0] adr, input logic [7:0] d [10], input int n,
                        output int nack_at);
        logic ack;
        nack_at = -1;
        bus_start();
        send_byte(adr, ack);
        if (!ack) nack_at = 0;
        for (int i = 0; i < n && nack_at < 0; i++) begin
            send_byte(d[i], ack);
            if (!ack) nack_at = i + 1;
        end
        bus_stop();
        wq(4);
    endtask

    task automatic t_reset();
        chk("R10 mute_l", mute_l, 1); chk("R10 mute_r", mute_r, 1);
        chk("R10 act_rj", act_rj, 0); chk("R10 dly_r", act_dly_r, 0);
        chk("R10 dly_l", act_dly_l, 0); chk("R10 frame", act_frame, 0);
        chk("R10 pkt", act_pkt, 0); chk("R10 sda_oe", sda_oe, 0);
        chk("R10 update", cfg_update, 0);
    endtask

    task automatic t_burst();
        logic [7:0] d [10] = '{8'h01, 8'h00, 8'h0F, 8'hFF, 8'h10, 8'h00, 8'h00, 8'h00, 8'h01, 8'h00};
        int na;
        xfer(8'hD2, d, 9, na);
        chk("R1 R3 burst acks", na, -1);
        chk("R9 mute cleared", {mute_l, mute_r}, 2'b00);
        chk("R6 dly_r 4095", act_dly_r, 16'h0FFF);
        chk("R6 dly_l 4096", act_dly_l, 16'h1000);
        chk("R8 one strobe", upd_cnt, 1);
    endtask

    task automatic t_staging();
        logic [7:0] d [10] = '{8'h02, 8'h01, 8'h23, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0};
        int na;
        xfer(8'hD2, d, 3, na);
        chk("R5 staged not active", act_dly_r, 16'h0FFF);
        d[0] = 8'h08; d[1] = 8'hFE;
        xfer(8'hD2, d, 2, na);
        chk("R7 zero commit dly", act_dly_r, 16'h0FFF);
        chk("R7 zero commit strobe", upd_cnt, 1);
        d[1] = 8'h01;
        xfer(8'hD2, d, 2, na);
        chk("R6 commit dly_r", act_dly_r, 16'h0123);
        chk("R8 strobe count", upd_cnt, 2);
    endtask

    task automatic t_rj_mode();
        logic [7:0] d [10] = '{8'h01, 8'h01, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0};
        int na;
        xfer(8'hD2, d, 2, na);
        chk("R5 rj waits", act_rj, 0);
        d[0] = 8'h06; d[1] = 8'h91; d[2] = 8'h10; d[3] = 8'h01;
        xfer(8'hD2, d, 4, na);
        chk("R6 rj", act_rj, 1); chk("R6 frame", act_frame, 8'h91);
        chk("R6 pkt", act_pkt, 8'h10); chk("R6 dly_l kept", act_dly_l, 16'h1000);
    endtask

    task automatic t_mute();
        logic [7:0] d [10] = '{8'h01, 8'hC0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0};
        int na;
        xfer(8'hD2, d, 2, na);
        chk("R9 both muted", {mute_l, mute_r}, 2'b11);
        chk("R5 rj unchanged", act_rj, 1);
        chk("R9 no strobe", upd_cnt, 3);
        d[1] = 8'h80;
        xfer(8'hD2, d, 2, na);
        chk("R9 left only", {mute_l, mute_r}, 2'b10);
    endtask

    task automatic t_address();
        logic [7:0] d [10] = '{8'h01, 8'h00, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0};
        int na;
        xfer(8'hD4, d, 2, na);
        chk("R1 foreign nack", na, 0);
        chk("R1 foreign ignored", {mute_l, mute_r}, 2'b10);
        xfer(8'hD3, d, 2, na);
        chk("R1 read nack", na, 0);
        addr_sel = 3'b101; wq(4);
        xfer(8'hD2, d, 2, na);
        chk("R1 old strap nack", na, 0);
        d[1] = 8'h40;
        xfer(8'hDA, d, 2, na);
        chk("R1 new strap ack", na, -1);
        chk("R9 right only", {mute_l, mute_r}, 2'b01);
    endtask

    task automatic t_pointer();
        logic [7:0] d [10] = '{8'h09, 8'h55, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0};
        int na;
        xfer(8'hDA, d, 2, na);
        chk("R2 ptr 0x09 nack", na, 1);
        d[0] = 8'h08; d[1] = 8'h03; d[2] = 8'h55; d[3] = 8'hAA;
        xfer(8'hDA, d, 4, na);
        chk("R3 bytes past 0x08 acked", na, -1);
        chk("R6 bits 7:1 ignored", upd_cnt, 4);
        chk("R3 past end no effect", act_frame, 8'h91);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hang expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        wq(5);
        rst_n = 1'b1;
        wq(5);
        t_reset();
        t_burst();
        t_staging();
        t_rj_mode();
        t_mute();
        t_address();
        t_pointer();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule